// File: doc/BRIEF.md
# Filter RAM Power Request Handshake

This block owns the power state of a snoop filter RAM. Software names a target state through a write strobe. The block latches that target and raises a request line toward an external power controller. The controller then answers with an accept pulse or a deny pulse. On accept, the target becomes the current state. On deny, the current state stays as it was. In both cases the request line drops.

At most one request is open at any time. A write that arrives while a request is open is refused. A write carrying a code outside the four legal ones is ignored.

Software reads a status word through a one-cycle read port. The word holds the pending flag, the last requested state and the current state. Both state fields use the same 3-bit encoding:

| Code | State |
|------|-------|
| 3'b000 | Off |
| 3'b001 | Static retention |
| 3'b011 | Dynamic retention |
| 3'b111 | On |

A read is served only while the RAM is in dynamic retention or On. In any other state the read returns zeros and raises an error flag.

Top module: `sfram_pwr_ctl`

## Requirements
- R1: After reset, `pwr_req` is 0, and both the current state and the last requested state are On (3'b111).
- R2: Suppose no request is open and `wr_en` is high with a legal code (3'b000, 3'b001, 3'b011 or 3'b111). On the next cycle `pwr_req` is 1 and `pwr_req_state` equals that code.
- R3: A write with any other code changes neither `pwr_req` nor `pwr_req_state`.
- R4: A write made while `pwr_req` is 1 is rejected, and `pwr_req_state` stays unchanged until the request closes.
- R5: If `pwr_accept` is high while `pwr_req` is 1, then on the next cycle `pwr_req` is 0 and the current state equals the requested state.
- R6: If `pwr_deny` is high and `pwr_accept` is low while `pwr_req` is 1, then on the next cycle `pwr_req` is 0 and the current state is unchanged.
- R7: Bit 0 of the status word equals `pwr_req` in the cycle the read is issued. It reads 0 once a request has been accepted or denied.
- R8: A read issued while the current state is 3'b011 or 3'b111 gives, one cycle later, `rd_valid`=1, `rd_err`=0 and `rd_data` = {zeros, current[6:4], last requested[3:1], pending[0]}.
- R9: A read issued in any other state gives, one cycle later, `rd_valid`=1, `rd_data`=0 and `rd_err`=1, each for one cycle.
- R10: `pwr_accept` and `pwr_deny` have no effect while no request is open. When both are high together during a request, accept wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software write strobe for a new target state |
| wr_state | input | 3 | Target state code |
| pwr_accept | input | 1 | Power controller accepts the open request |
| pwr_deny | input | 1 | Power controller denies the open request |
| rd_en | input | 1 | Status read strobe |
| pwr_req | output | 1 | Request open toward the power controller |
| pwr_req_state | output | 3 | Last requested state code |
| rd_valid | output | 1 | Read response valid, one cycle after `rd_en` |
| rd_data | output | DATA_W | Status word, or zeros on a refused read |
| rd_err | output | 1 | Read refused because of the current state |

## Verification
The embedded assertions check these rules on every cycle:
- A request closes on the cycle after any accept or deny, and the current state moves only on accept.
- The requested field holds steady while a request is open.
- A refused read always returns zeros together with a valid pulse.

Some behaviour only the directed scenarios can show. These are the exact layout of the status word, the filtering of illegal codes, and the choice between refusing and serving a read as the state walks through Off, both retention levels and On. The scenarios also show that stray or overlapping controller responses are handled as specified.

// File: rtl/sfram_pwr_ctl.sv
module sfram_pwr_ctl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_state,
  input  logic              pwr_accept,
  input  logic              pwr_deny,
  input  logic              rd_en,
  output logic              pwr_req,
  output logic [2:0]        pwr_req_state,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_err
);
  localparam logic [2:0] ST_OFF  = 3'b000;
  localparam logic [2:0] ST_SRET = 3'b001;
  localparam logic [2:0] ST_DRET = 3'b011;
  localparam logic [2:0] ST_ON   = 3'b111;
  localparam int FIELD_W = 7;
  localparam int PAD_W   = DATA_W - FIELD_W;

  logic [2:0] cur_q, req_q;
  logic       pend_q;

  wire code_ok  = (wr_state == ST_OFF) || (wr_state == ST_SRET) ||
                  (wr_state == ST_DRET) || (wr_state == ST_ON);
  wire take     = wr_en && code_ok && !pend_q;
  wire close_ok = pend_q && pwr_accept;
  wire close_no = pend_q && pwr_deny && !pwr_accept;
  wire readable = (cur_q == ST_DRET) || (cur_q == ST_ON);

  wire [DATA_W-1:0] status_word = {{PAD_W{1'b0}}, cur_q, req_q, pend_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= ST_ON;
      req_q  <= ST_ON;
      pend_q <= 1'b0;
    end else begin
      if (take) begin
        req_q  <= wr_state;
        pend_q <= 1'b1;
      end else if (close_ok) begin
        cur_q  <= req_q;
        pend_q <= 1'b0;
      end else if (close_no) begin
        pend_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_err   <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_err   <= rd_en && !readable;
      rd_data  <= (rd_en && readable) ? status_word : '0;
    end
  end

  assign pwr_req       = pend_q;
  assign pwr_req_state = req_q;

  AST_ACCEPT_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_req && pwr_accept) |=> (!pwr_req && cur_q == $past(pwr_req_state))); // R5
  AST_DENY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_req && pwr_deny && !pwr_accept) |=> (!pwr_req && $stable(cur_q))); // R6
  AST_REQ_FIELD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_req |=> $stable(pwr_req_state)); // R4
  AST_IDLE_WRITE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_req && wr_en && code_ok) |=> (pwr_req && pwr_req_state == $past(wr_state))); // R2
  AST_REFUSED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> (rd_valid && rd_data == '0)); // R9
  AST_STRAY_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_req && !wr_en) |=> (!pwr_req && $stable(cur_q))); // R10
endmodule

// File: tb/sfram_pwr_ctl_test.sv
`timescale 1ns/1ps
module sfram_pwr_ctl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, pwr_accept = 0, pwr_deny = 0, rd_en = 0;
  logic [2:0] wr_state = 3'b000;
  logic pwr_req, rd_valid, rd_err;
  logic [2:0] pwr_req_state;
  logic [7:0] rd_data;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  sfram_pwr_ctl #(.DATA_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_state(wr_state),
    .pwr_accept(pwr_accept), .pwr_deny(pwr_deny), .rd_en(rd_en),
    .pwr_req(pwr_req), .pwr_req_state(pwr_req_state), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_err(rd_err));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic write_state(logic [2:0] code);
    wr_en = 1; wr_state = code; step(); wr_en = 0;
  endtask

  task automatic respond(logic a, logic d);
    pwr_accept = a; pwr_deny = d; step(); pwr_accept = 0; pwr_deny = 0;
  endtask

  task automatic read_expect(string req, logic err, logic [7:0] word);
    rd_en = 1; step(); rd_en = 0;
    chk({req, " valid"}, rd_valid, 1);
    chk({req, " err"}, rd_err, err);
    chk({req, " data"}, rd_data, word);
    step();
    chk({req, " valid drops"}, rd_valid, 0);
  endtask

  function automatic logic [7:0] word(logic [2:0] cur, logic [2:0] last, logic p);
    return {1'b0, cur, last, p};
  endfunction

  task automatic t_reset();
    chk("R1 req", pwr_req, 0);
    chk("R1 req_state", pwr_req_state, 3'b111);
    read_expect("R1 R8 reset read", 0, word(3'b111, 3'b111, 0));
  endtask

  task automatic t_accept_to_dret();
    write_state(3'b011);
    chk("R2 req", pwr_req, 1);
    chk("R2 state", pwr_req_state, 3'b011);
    read_expect("R7 pending read", 0, word(3'b111, 3'b011, 1));
    respond(1, 0);
    chk("R5 req drops", pwr_req, 0);
    read_expect("R5 R7 R8 after accept", 0, word(3'b011, 3'b011, 0));
  endtask

  task automatic t_reject_while_pending();
    write_state(3'b000);
    write_state(3'b111);
    chk("R4 req held", pwr_req, 1);
    chk("R4 field held", pwr_req_state, 3'b000);
    respond(0, 1);
    chk("R6 req drops", pwr_req, 0);
    read_expect("R6 state kept", 0, word(3'b011, 3'b000, 0));
  endtask

  task automatic t_illegal_code();
    write_state(3'b010);
    chk("R3 no req", pwr_req, 0);
    chk("R3 field", pwr_req_state, 3'b000);
    write_state(3'b110);
    chk("R3 no req 2", pwr_req, 0);
  endtask

  task automatic t_stray_and_both();
    respond(1, 1);
    chk("R10 stray no req", pwr_req, 0);
    read_expect("R10 stray state", 0, word(3'b011, 3'b000, 0));
    write_state(3'b001);
    respond(1, 1);
    chk("R10 both req drops", pwr_req, 0);
    read_expect("R9 refused in static", 1, 8'h00);
  endtask

  task automatic t_off_and_back();
    write_state(3'b000);
    respond(1, 0);
    read_expect("R9 refused in off", 1, 8'h00);
    write_state(3'b111);
    respond(1, 0);
    read_expect("R8 back on", 0, word(3'b111, 3'b111, 0));
  endtask

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_accept_to_dret();
    t_reject_while_pending();
    t_illegal_code();
    t_stray_and_both();
    t_off_and_back();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule